// File: doc/BRIEF.md
# Hart Timer and Doorbell Controller

This block gives every hart of a small multi-hart cluster two machine-level interrupt sources. The first is a timer line, raised while the hart's 64-bit deadline is at or below a shared free-running 64-bit time count. The second is a doorbell line that software on any hart raises or clears through a register write. The shared count advances by one on each cycle in which the timebase tick-enable input is high. It cannot be written.

All registers sit behind a plain 32-bit register bus. The bus has a byte address, separate read and write strobes, write data and registered read data. The byte address space holds three regions, each with a base offset set by a parameter. Each hart gets a 4-byte doorbell slot and an 8-byte deadline slot. The deadline slot holds two 32-bit halves that software updates one at a time. The time count is read as two 32-bit words.

Every write to a deadline half re-evaluates that hart's timer line, and so does every change of the count. Software moves a deadline into the future to silence the line.

Top module: `hart_tick_ctrl`

## Requirements
- R1: After reset the time count is 0, every deadline is 0, every doorbell line is 0, every timer line is 1 (because 0 <= 0), and the read data is 0.
- R2: The time count increases by exactly one on each clock edge where tick_en is 1 and holds otherwise. Its low word reads at CNT_BASE and its high word at CNT_BASE+4.
- R3: Writes to CNT_BASE or CNT_BASE+4 leave the time count unchanged.
- R4: Hart h's doorbell slot is at DOOR_BASE+4*h. A write sets soft_irq[h] to bit 0 of the write data at the next edge. A read returns that line in bit 0 with all other bits 0.
- R5: Hart h's deadline slot is at CMP_BASE+8*h. Bits 31:0 read and write at offset 0 and bits 63:32 at offset 4.
- R6: A write to one deadline half changes only that half; the other half keeps its value, whichever half is written first.
- R7: timer_irq[h] is 1 exactly when deadline[h] <= time count, compared as unsigned 64-bit values. The line reflects a deadline write in the cycle after the write strobe. It also rises with no write once the count reaches the deadline.
- R8: An access is ignored if its address has bits 1:0 nonzero, if it falls at offset 2, 6 or other non-slot offsets, or if it lies outside all three regions (which includes slots of hart indices at or beyond NUM_HARTS). An ignored read returns 0 and an ignored write changes no deadline, doorbell line or timer line.
- R9: bus_rdata is loaded at the clock edge where bus_rd is 1 and holds its value until the next read.
- R10: After the first half of a split deadline update, the timer line follows the intermediate 64-bit value made of the new half and the old other half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase tick; count advances when high |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| timer_irq | output | NUM_HARTS | Per-hart timer pending lines |
| soft_irq | output | NUM_HARTS | Per-hart doorbell pending lines |

## Verification
The bench builds the block with three harts, a 12-bit address, and regions at 0x000, 0x100 and 0x1F8. Three harts is not a power of two, so the fourth slot position in the doorbell and deadline address ranges lies outside the regions and must read as zero. The small bases keep misaligned, unmapped and beyond-count addresses within a few bytes of valid slots. Deadlines are placed one tick above and exactly at the count. Splitting them across the high word exercises both update orders.

// File: rtl/htc_pkg.sv
`timescale 1ns/1ps
package htc_pkg;
  // Which region a bus address decodes to
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_DOOR = 2'd1,
    RGN_CMP  = 2'd2,
    RGN_CNT  = 2'd3
  } rgn_e;
endpackage

// File: rtl/htc_decode.sv
`timescale 1ns/1ps
module htc_decode
  import htc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_HARTS = 4,
  parameter int DOOR_BASE = 'h0000,
  parameter int CMP_BASE  = 'h4000,
  parameter int CNT_BASE  = 'hBFF8,
  localparam int HART_W   = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output rgn_e              rgn_o,
  output logic              hi_o,
  output logic [HART_W-1:0] hart_o
);
  localparam logic [ADDR_W-1:0] DOOR_SPAN = ADDR_W'(4 * NUM_HARTS);
  localparam logic [ADDR_W-1:0] CMP_SPAN  = ADDR_W'(8 * NUM_HARTS);

  logic [ADDR_W-1:0] door_off, cmp_off, cnt_off;
  logic in_door, in_cmp, in_cnt;

  always_comb begin
    door_off = addr_i - ADDR_W'(DOOR_BASE);
    cmp_off  = addr_i - ADDR_W'(CMP_BASE);
    cnt_off  = addr_i - ADDR_W'(CNT_BASE);
    in_door  = (addr_i >= ADDR_W'(DOOR_BASE)) && (door_off < DOOR_SPAN)
               && (door_off[1:0] == 2'b00);
    in_cmp   = (addr_i >= ADDR_W'(CMP_BASE)) && (cmp_off < CMP_SPAN)
               && (cmp_off[1:0] == 2'b00);
    in_cnt   = (cnt_off == '0) || (cnt_off == ADDR_W'(4));

    rgn_o  = RGN_NONE;
    hi_o   = 1'b0;
    hart_o = '0;
    if (in_door) begin
      rgn_o  = RGN_DOOR;
      hart_o = HART_W'(door_off >> 2);
    end else if (in_cmp) begin
      rgn_o  = RGN_CMP;
      hi_o   = cmp_off[2];
      hart_o = HART_W'(cmp_off >> 3);
    end else if (in_cnt) begin
      rgn_o  = RGN_CNT;
      hi_o   = cnt_off[2];
    end
  end
endmodule

// File: rtl/htc_counter.sv
`timescale 1ns/1ps
module htc_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;

  p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));
  p_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_o));
endmodule

// File: rtl/htc_doorbell.sv
`timescale 1ns/1ps
module htc_doorbell #(
  parameter int NUM_HARTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_HARTS-1:0] wr_en_i,
  input  logic                 wr_bit_i,
  output logic [NUM_HARTS-1:0] soft_o
);
  logic [NUM_HARTS-1:0] soft_q, soft_d;

  always_comb begin
    soft_d = soft_q;
    for (int h = 0; h < NUM_HARTS; h++) begin
      if (wr_en_i[h]) soft_d[h] = wr_bit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        soft_q <= '0;
    else if (|wr_en_i) soft_q <= soft_d;
  end

  assign soft_o = soft_q;

  p_one_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en_i));
  p_untouched_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i == '0) |=> $stable(soft_o));
endmodule

// File: rtl/htc_cmp_bank.sv
`timescale 1ns/1ps
module htc_cmp_bank #(
  parameter int NUM_HARTS = 4,
  parameter int DATA_W    = 32,
  localparam int CNT_W    = 2 * DATA_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_HARTS-1:0]            wr_lo_i,
  input  logic [NUM_HARTS-1:0]            wr_hi_i,
  input  logic [DATA_W-1:0]               wdata_i,
  input  logic [CNT_W-1:0]                cnt_i,
  input  logic [CNT_W-1:0]                cnt_nxt_i,
  output logic [NUM_HARTS-1:0][CNT_W-1:0] cmp_o,
  output logic [NUM_HARTS-1:0]            timer_o
);
  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    logic [CNT_W-1:0] dl_q, dl_d;
    logic             due_q, due_d;

    always_comb begin
      dl_d = dl_q;
      if (wr_lo_i[h]) dl_d[DATA_W-1:0]     = wdata_i;
      if (wr_hi_i[h]) dl_d[CNT_W-1:DATA_W] = wdata_i;
      due_d = (dl_d <= cnt_nxt_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dl_q  <= '0;
        due_q <= 1'b1;
      end else begin
        if (wr_lo_i[h] || wr_hi_i[h]) dl_q <= dl_d;
        due_q <= due_d;
      end
    end

    assign cmp_o[h]   = dl_q;
    assign timer_o[h] = due_q;

    p_line_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      timer_o[h] == (cmp_o[h] <= cnt_i));
    p_lo_keeps_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo_i[h] && !wr_hi_i[h]) |=>
        (cmp_o[h][CNT_W-1:DATA_W] == $past(cmp_o[h][CNT_W-1:DATA_W]))
        && (cmp_o[h][DATA_W-1:0] == $past(wdata_i)));
    p_hi_keeps_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi_i[h] && !wr_lo_i[h]) |=>
        (cmp_o[h][DATA_W-1:0] == $past(cmp_o[h][DATA_W-1:0]))
        && (cmp_o[h][CNT_W-1:DATA_W] == $past(wdata_i)));
  end
endmodule

// File: rtl/hart_tick_ctrl.sv
`timescale 1ns/1ps
module hart_tick_ctrl
  import htc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_HARTS = 4,
  parameter int DOOR_BASE = 'h0000,
  parameter int CMP_BASE  = 'h4000,
  parameter int CNT_BASE  = 'hBFF8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_HARTS-1:0] timer_irq,
  output logic [NUM_HARTS-1:0] soft_irq
);
  localparam int DATA_W = 32;
  localparam int CNT_W  = 2 * DATA_W;
  localparam int HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  rgn_e                           dec_rgn;
  logic                           dec_hi;
  logic [HART_W-1:0]              dec_hart;
  logic [CNT_W-1:0]               cnt, cnt_nxt;
  logic [NUM_HARTS-1:0][CNT_W-1:0] cmp;
  logic [NUM_HARTS-1:0]           wr_door, wr_lo, wr_hi;
  logic [DATA_W-1:0]              rdata_q, rdata_d;

  htc_decode #(
    .ADDR_W(ADDR_W), .NUM_HARTS(NUM_HARTS),
    .DOOR_BASE(DOOR_BASE), .CMP_BASE(CMP_BASE), .CNT_BASE(CNT_BASE)
  ) u_decode (
    .addr_i(bus_addr), .rgn_o(dec_rgn), .hi_o(dec_hi), .hart_o(dec_hart)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_wsel
    logic hit;
    assign hit        = bus_wr && (dec_hart == HART_W'(h));
    assign wr_door[h] = hit && (dec_rgn == RGN_DOOR);
    assign wr_lo[h]   = hit && (dec_rgn == RGN_CMP) && !dec_hi;
    assign wr_hi[h]   = hit && (dec_rgn == RGN_CMP) && dec_hi;
  end

  htc_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cnt_o(cnt), .cnt_nxt_o(cnt_nxt)
  );

  htc_doorbell #(.NUM_HARTS(NUM_HARTS)) u_doorbell (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_door),
    .wr_bit_i(bus_wdata[0]), .soft_o(soft_irq)
  );

  htc_cmp_bank #(.NUM_HARTS(NUM_HARTS), .DATA_W(DATA_W)) u_cmp_bank (
    .clk(clk), .rst_n(rst_n), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wdata_i(bus_wdata), .cnt_i(cnt), .cnt_nxt_i(cnt_nxt),
    .cmp_o(cmp), .timer_o(timer_irq)
  );

  // Read path: select, then register on the read strobe
  always_comb begin
    rdata_d = '0;
    unique case (dec_rgn)
      RGN_DOOR: rdata_d = {{(DATA_W-1){1'b0}}, soft_irq[dec_hart]};
      RGN_CMP:  rdata_d = dec_hi ? cmp[dec_hart][CNT_W-1:DATA_W]
                                 : cmp[dec_hart][DATA_W-1:0];
      RGN_CNT:  rdata_d = dec_hi ? cnt[CNT_W-1:DATA_W] : cnt[DATA_W-1:0];
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  p_cnt_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && dec_rgn == RGN_CNT && !tick_en) |=> $stable(cnt));
  p_stray_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && dec_rgn == RGN_NONE) |=> ($stable(soft_irq) && $stable(cmp)));
  p_stray_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && dec_rgn == RGN_NONE) |=> (bus_rdata == '0));
endmodule

// File: tb/hart_tick_ctrl_tb_top.sv
`timescale 1ns/1ps
module hart_tick_ctrl_tb_top;
  localparam int AW = 12;
  localparam int NH = 3;
  localparam logic [AW-1:0] A_DOOR = 12'h000;
  localparam logic [AW-1:0] A_CMP  = 12'h100;
  localparam logic [AW-1:0] A_CNT  = 12'h1F8;

  logic          clk, rst_n, tick_en, bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NH-1:0] timer_irq, soft_irq;

  int total = 0;
  int bad   = 0;

  hart_tick_ctrl #(
    .ADDR_W(AW), .NUM_HARTS(NH),
    .DOOR_BASE('h000), .CMP_BASE('h100), .CNT_BASE('h1F8)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .timer_irq(timer_irq), .soft_irq(soft_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Scoreboard queues filled by the read driver
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen;

  always @(posedge clk) rd_seen <= bus_rd;

  task automatic check(input logic [31:0] got, input logic [31:0] exp,
                       input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  // Monitor: compare registered read data the half cycle after capture
  always @(negedge clk) begin
    if (rd_seen === 1'b1) begin
      if (exp_q.size() == 0) check(32'hDEAD, 32'h0, "scoreboard underflow");
      else check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [31:0] exp,
                          input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(32'(soft_irq), 32'h0, "R1 doorbell lines");
    check(32'(timer_irq), 32'h7, "R1 timer lines");
    check(bus_rdata, 32'h0, "R1 read data");
    bus_read(A_CMP + 12'h008, 32'h0, "R1 deadline hart1 low");
    bus_read(A_CMP + 12'h00C, 32'h0, "R1 deadline hart1 high");
    bus_read(A_CNT, 32'h0, "R1 count low");

    // R2 counting
    tick(5);
    bus_read(A_CNT, 32'h5, "R2 count low after 5 ticks");
    bus_read(A_CNT + 12'h004, 32'h0, "R2 count high");

    // R3 count writes ignored
    bus_write(A_CNT, 32'hFFFF_0000);
    bus_write(A_CNT + 12'h004, 32'h1234_5678);
    bus_read(A_CNT, 32'h5, "R3 count low unchanged");
    bus_read(A_CNT + 12'h004, 32'h0, "R3 count high unchanged");

    // R4 doorbells
    bus_write(A_DOOR + 12'h004, 32'h3);
    check(32'(soft_irq), 32'h2, "R4 hart1 doorbell set");
    bus_read(A_DOOR + 12'h004, 32'h1, "R4 hart1 doorbell read");
    bus_write(A_DOOR + 12'h008, 32'h1);
    bus_write(A_DOOR + 12'h004, 32'h2);
    check(32'(soft_irq), 32'h4, "R4 bit0 clears hart1, hart2 set");
    bus_read(A_DOOR + 12'h008, 32'h1, "R4 hart2 doorbell read");

    // R5/R7 hart0 deadline above count
    bus_write(A_CMP, 32'h10);
    check(32'(timer_irq[0]), 32'h0, "R7 deadline 16 > count 5");
    bus_read(A_CMP, 32'h10, "R5 hart0 low");
    bus_read(A_CMP + 12'h004, 32'h0, "R5 hart0 high");
    // R6/R10 high then low
    bus_write(A_CMP + 12'h004, 32'h1);
    bus_read(A_CMP, 32'h10, "R6 low kept after high write");
    bus_write(A_CMP, 32'h3);
    check(32'(timer_irq[0]), 32'h0, "R10 intermediate 0x1_00000003");
    bus_read(A_CMP + 12'h004, 32'h1, "R6 high kept after low write");
    bus_write(A_CMP + 12'h004, 32'h0);
    check(32'(timer_irq[0]), 32'h1, "R7 deadline 3 <= count 5");

    // R6/R10 low then high on hart2 (deadline 0 before)
    bus_write(A_CMP + 12'h014, 32'h2);
    check(32'(timer_irq[2]), 32'h0, "R10 intermediate 0x2_00000000");
    bus_write(A_CMP + 12'h010, 32'h7);
    check(32'(timer_irq[2]), 32'h0, "R10 intermediate 0x2_00000007");
    bus_write(A_CMP + 12'h014, 32'h0);
    check(32'(timer_irq[2]), 32'h0, "R7 deadline 7 > count 5");
    bus_read(A_CMP + 12'h010, 32'h7, "R6 hart2 low kept");
    tick(1);
    check(32'(timer_irq[2]), 32'h0, "R7 count 6 below deadline 7");
    tick(1);
    check(32'(timer_irq[2]), 32'h1, "R7 rises when count reaches 7");
    bus_write(A_CMP + 12'h008, 32'h8);
    check(32'(timer_irq), 32'h5, "R7 deadline one above count");

    // R8 ignored accesses
    bus_write(A_CMP + 12'h002, 32'h0);
    bus_write(A_CMP + 12'h018, 32'h0);
    bus_write(A_DOOR + 12'h001, 32'h1);
    bus_write(A_DOOR + 12'h00C, 32'h1);
    bus_write(12'h080, 32'h1);
    check(32'(timer_irq), 32'h5, "R8 timer lines untouched");
    check(32'(soft_irq), 32'h4, "R8 doorbell lines untouched");
    bus_read(A_CMP + 12'h008, 32'h8, "R8 hart1 deadline intact");
    bus_read(A_CMP + 12'h018, 32'h0, "R8 beyond hart count deadline");
    bus_read(A_CMP + 12'h001, 32'h0, "R8 misaligned deadline");
    bus_read(A_DOOR + 12'h00C, 32'h0, "R8 beyond hart count doorbell");
    bus_read(A_DOOR + 12'h009, 32'h0, "R8 misaligned doorbell");
    bus_read(12'h080, 32'h0, "R8 unmapped");
    bus_read(A_CNT + 12'h008, 32'h0, "R8 past count window");

    // R9 read data holds
    bus_read(A_CMP, 32'h3, "R9 hart0 low");
    repeat (3) @(negedge clk);
    check(bus_rdata, 32'h3, "R9 held after idle cycles");

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule